// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic stage of a small 8-bit RISC core. Every clock it takes an operation code and two byte operands, where the second operand may be a register value or an immediate that the decoder has already selected. It returns a byte result and a write-enable for the register file. It also keeps six status flags in a register of its own: half carry, sign, overflow, negative, zero and carry.

The result and the write-enable are combinational, so they are valid in the same cycle as the operation. The flags are written at the next rising edge. The carry that feeds add-with-carry, subtract-with-carry, compare-with-carry and the rotates is read from that flag register. Each operation updates only its own group of flags and leaves the rest as they were.

The subtract-with-carry and compare-with-carry operations can only clear the zero flag, never set it. This lets a multi-byte subtract or compare, run from the least significant byte up, end with a zero flag that describes the whole value.

Top module: `alu8_flags`

## Requirements
- R1: Flag bits are C=bit0, Z=bit1, N=bit2, V=bit3, S=bit4, H=bit5. A synchronous active-low reset clears all six.
- R2: Operation codes are 0 none, 1 add, 2 add-with-carry, 3 sub, 4 sub-with-carry, 5 compare, 6 compare-with-carry, 7 and, 8 or, 9 xor, 10 one's complement, 11 negate, 12 increment, 13 decrement, 14 logical shift right, 15 rotate right, 16 arithmetic shift right, 17 shift left, 18 rotate left, 19 nibble swap. Codes 0 and 20–31 write no result and change no flag.
- R3: Add and add-with-carry produce a+b(+C) and update H (carry out of bit 3), V (signed overflow), N, Z and C (carry out of bit 7).
- R4: Sub, sub-with-carry, compare and compare-with-carry compute a−b(−C) and update H (borrow from bit 4), V, N, Z and C (borrow). The two compares drive the write-enable low.
- R5: For sub-with-carry and compare-with-carry, Z becomes 1 only if the byte result is zero and Z was already 1.
- R6: And, or and xor update Z and N, force V to 0, and leave C and H unchanged.
- R7: One's complement gives 0xFF−a, sets C to 1 and V to 0. Negate gives 0x00−a, with C=1 unless a is 0, V=1 only for a=0x80, and H set when the low nibble of a is nonzero.
- R8: Increment and decrement update only Z, N, V and S. V is 1 for increment of 0x7F and for decrement of 0x80. C and H are preserved.
- R9: The right shifts take bit 0 into C. Bit 7 of the result is 0 for the logical shift, the old C for the rotate, and the old bit 7 for the arithmetic shift. V is N xor C. H is unchanged.
- R10: Shift left and rotate left take bit 7 into C and bit 3 into H. Bit 0 of the result is 0 for the shift and the old C for the rotate. V is N xor C.
- R11: Nibble swap exchanges the two halves of a, writes the result and changes no flag.
- R12: Whenever N or V is updated, S is written as N xor V.
- R13: The result and write-enable are valid in the cycle the operation is presented. The new flags appear after the next rising clock edge and are used by the operation in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 5 | Operation code |
| opd_a_i | input | 8 | Destination operand |
| opd_b_i | input | 8 | Source register or immediate operand |
| res_o | output | 8 | Result byte |
| res_we_o | output | 1 | Result write-enable |
| flags_o | output | 6 | Status flags {H,S,V,N,Z,C} |

## Verification
Two things meet in the same cycle: the flag write of one operation and the flag read of the next. An add-with-carry, rotate or chained compare sees the carry and zero that its predecessor wrote at the edge just before it. The bench presents a new operation every cycle, both in random streams and in directed multi-byte compare chains. It keeps its own flag model, updated from the requirements, and judges each result against that model. Each flag register value is compared one edge later.

// File: rtl/alu8_pkg.sv
// Shared constants for the 8-bit ALU: flag bit positions and operation codes.
// Assumes the flag layout is fixed, because the core's branch logic decodes it.
package alu8_pkg;
    localparam int FLAG_W = 6;
    localparam int F_C = 0;
    localparam int F_Z = 1;
    localparam int F_N = 2;
    localparam int F_V = 3;
    localparam int F_S = 4;
    localparam int F_H = 5;

    localparam int OP_W = 5;
    typedef logic [OP_W-1:0] op_t;

    localparam op_t OP_NOP  = 5'd0;
    localparam op_t OP_ADD  = 5'd1;
    localparam op_t OP_ADC  = 5'd2;
    localparam op_t OP_SUB  = 5'd3;
    localparam op_t OP_SBC  = 5'd4;
    localparam op_t OP_CP   = 5'd5;
    localparam op_t OP_CPC  = 5'd6;
    localparam op_t OP_AND  = 5'd7;
    localparam op_t OP_OR   = 5'd8;
    localparam op_t OP_XOR  = 5'd9;
    localparam op_t OP_COM  = 5'd10;
    localparam op_t OP_NEG  = 5'd11;
    localparam op_t OP_INC  = 5'd12;
    localparam op_t OP_DEC  = 5'd13;
    localparam op_t OP_LSR  = 5'd14;
    localparam op_t OP_ROR  = 5'd15;
    localparam op_t OP_ASR  = 5'd16;
    localparam op_t OP_LSL  = 5'd17;
    localparam op_t OP_ROL  = 5'd18;
    localparam op_t OP_SWAP = 5'd19;

    // Flag groups written by each class of operation.
    localparam logic [FLAG_W-1:0] M_ALL   = 6'b111111;
    localparam logic [FLAG_W-1:0] M_LOGIC = 6'b011110; // S V N Z
    localparam logic [FLAG_W-1:0] M_CARRY = 6'b011111; // S V N Z C
    localparam logic [FLAG_W-1:0] M_NONE  = 6'b000000;
endpackage

// File: rtl/alu8_addsub.sv
// Adder/subtractor with half-carry and signed overflow detection.
// Assumes a W-bit word with the half-carry taken at the middle of the word.
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o,
    output logic         c_o,
    output logic         h_o,
    output logic         v_o
);
    localparam int MSB = W - 1;
    localparam int HB  = W / 2 - 1;

    logic [W:0] full;

    // Wide sum or difference; the top bit is carry-out or borrow.
    always_comb begin
        if (sub_i)
            full = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
        else
            full = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    end

    assign res_o = full[W-1:0];
    assign c_o   = full[W];

    // Half-carry (borrow) out of the low half and signed overflow from the operand signs.
    always_comb begin
        if (sub_i) begin
            h_o = (~a_i[HB] & b_i[HB]) | (b_i[HB] & res_o[HB]) | (res_o[HB] & ~a_i[HB]);
            v_o = (a_i[MSB] & ~b_i[MSB] & ~res_o[MSB]) | (~a_i[MSB] & b_i[MSB] & res_o[MSB]);
        end else begin
            h_o = (a_i[HB] & b_i[HB]) | (b_i[HB] & ~res_o[HB]) | (~res_o[HB] & a_i[HB]);
            v_o = (a_i[MSB] & b_i[MSB] & ~res_o[MSB]) | (~a_i[MSB] & ~b_i[MSB] & res_o[MSB]);
        end
    end
endmodule

// File: rtl/alu8_bitops.sv
// Bitwise logic, complement, shifts, rotates and half swap.
// Assumes the caller picks which operations use its result; the output is
// the operand unchanged for codes it does not handle.
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  op_t          op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] res_o,
    output logic         shout_o
);
    localparam int HALF = W / 2;

    // Result and shifted-out bit for each non-arithmetic operation.
    always_comb begin
        res_o   = a_i;
        shout_o = 1'b0;
        case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_COM:  res_o = ~a_i;
            OP_LSR:  begin res_o = {1'b0,     a_i[W-1:1]}; shout_o = a_i[0];   end
            OP_ROR:  begin res_o = {cin_i,    a_i[W-1:1]}; shout_o = a_i[0];   end
            OP_ASR:  begin res_o = {a_i[W-1], a_i[W-1:1]}; shout_o = a_i[0];   end
            OP_LSL:  begin res_o = {a_i[W-2:0], 1'b0};     shout_o = a_i[W-1]; end
            OP_ROL:  begin res_o = {a_i[W-2:0], cin_i};    shout_o = a_i[W-1]; end
            OP_SWAP: res_o = {a_i[HALF-1:0], a_i[W-1:HALF]};
            default: res_o = a_i;
        endcase
    end
endmodule

// File: rtl/alu8_flag_reg.sv
// Status flag register; writes only the bits selected by the update mask.
// Assumes a synchronous active-low reset that clears every flag.
module alu8_flag_reg #(
    parameter int FW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] mask_i,
    input  logic [FW-1:0] nxt_i,
    output logic [FW-1:0] q_o
);
    // Merge new flag values into the held ones under the mask.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= '0;
        else
            q_o <= (q_o & ~mask_i) | (nxt_i & mask_i);
    end
endmodule

// File: rtl/alu8_flags.sv
// Top of the 8-bit ALU: routes operands to the adder or bit unit, selects
// the result, forms the new flags and the per-operation update mask.
// Assumes operand b is already the register or immediate chosen by the decoder.
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_i,
    input  logic [W-1:0]      opd_a_i,
    input  logic [W-1:0]      opd_b_i,
    output logic [W-1:0]      res_o,
    output logic              res_we_o,
    output logic [FLAG_W-1:0] flags_o
);
    localparam int MSB = W - 1;
    localparam int HB  = W / 2 - 1;

    logic [W-1:0]      as_a, as_b, as_res, bo_res;
    logic              as_cin, as_sub, as_c, as_h, as_v, bo_c;
    logic              use_arith, z_chain;
    logic [FLAG_W-1:0] upd_mask, nxt_flags;
    logic              n_new, z_new, v_new, c_new, h_new;

    // Operand routing, result source, write-enable and flag mask per operation.
    always_comb begin
        as_a      = opd_a_i;
        as_b      = opd_b_i;
        as_cin    = 1'b0;
        as_sub    = 1'b0;
        use_arith = 1'b1;
        z_chain   = 1'b0;
        res_we_o  = 1'b1;
        upd_mask  = M_NONE;
        case (op_i)
            OP_ADD: upd_mask = M_ALL;
            OP_ADC: begin upd_mask = M_ALL; as_cin = flags_o[F_C]; end
            OP_SUB: begin upd_mask = M_ALL; as_sub = 1'b1; end
            OP_SBC: begin upd_mask = M_ALL; as_sub = 1'b1; as_cin = flags_o[F_C]; z_chain = 1'b1; end
            OP_CP:  begin upd_mask = M_ALL; as_sub = 1'b1; res_we_o = 1'b0; end
            OP_CPC: begin
                upd_mask = M_ALL; as_sub = 1'b1; as_cin = flags_o[F_C];
                z_chain = 1'b1; res_we_o = 1'b0;
            end
            OP_NEG: begin upd_mask = M_ALL; as_sub = 1'b1; as_a = '0; as_b = opd_a_i; end
            OP_INC: begin upd_mask = M_LOGIC; as_b = W'(1); end
            OP_DEC: begin upd_mask = M_LOGIC; as_b = W'(1); as_sub = 1'b1; end
            OP_AND, OP_OR, OP_XOR: begin upd_mask = M_LOGIC; use_arith = 1'b0; end
            OP_COM, OP_LSR, OP_ROR, OP_ASR: begin upd_mask = M_CARRY; use_arith = 1'b0; end
            OP_LSL, OP_ROL: begin upd_mask = M_ALL; use_arith = 1'b0; end
            OP_SWAP: use_arith = 1'b0;
            default: res_we_o = 1'b0;
        endcase
    end

    alu8_addsub #(.W(W)) u_addsub (
        .a_i   (as_a),
        .b_i   (as_b),
        .cin_i (as_cin),
        .sub_i (as_sub),
        .res_o (as_res),
        .c_o   (as_c),
        .h_o   (as_h),
        .v_o   (as_v)
    );

    alu8_bitops #(.W(W)) u_bitops (
        .op_i    (op_i),
        .a_i     (opd_a_i),
        .b_i     (opd_b_i),
        .cin_i   (flags_o[F_C]),
        .res_o   (bo_res),
        .shout_o (bo_c)
    );

    assign res_o = use_arith ? as_res : bo_res;

    // New flag values; the mask decides which of them are stored.
    always_comb begin
        n_new = res_o[MSB];
        z_new = (res_o == '0) & (~z_chain | flags_o[F_Z]);
        c_new = as_c;
        h_new = as_h;
        v_new = as_v;
        case (op_i)
            OP_AND, OP_OR, OP_XOR: v_new = 1'b0;
            OP_COM: begin c_new = 1'b1; v_new = 1'b0; end
            OP_LSR, OP_ROR, OP_ASR: begin c_new = bo_c; v_new = n_new ^ bo_c; end
            OP_LSL, OP_ROL: begin
                c_new = bo_c; v_new = n_new ^ bo_c; h_new = opd_a_i[HB];
            end
            default: ;
        endcase
        nxt_flags        = '0;
        nxt_flags[F_C]   = c_new;
        nxt_flags[F_Z]   = z_new;
        nxt_flags[F_N]   = n_new;
        nxt_flags[F_V]   = v_new;
        nxt_flags[F_S]   = n_new ^ v_new;
        nxt_flags[F_H]   = h_new;
    end

    alu8_flag_reg #(.FW(FLAG_W)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .mask_i (upd_mask),
        .nxt_i  (nxt_flags),
        .q_o    (flags_o)
    );
endmodule

// File: rtl/alu8_flags_chk.sv
// Property checker for the ALU flag behaviour, bound to the top module.
// Assumes it observes only the top-level ports.
module alu8_flags_chk
    import alu8_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [OP_W-1:0]   op_i,
    input logic              res_we_o,
    input logic [FLAG_W-1:0] flags_o
);
    // R12
    sign_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[F_S] == (flags_o[F_N] ^ flags_o[F_V]));

    // R4
    compare_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CP || op_i == OP_CPC) |-> !res_we_o);

    // R5
    sticky_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == OP_SBC || op_i == OP_CPC) && !flags_o[F_Z]) |=> !flags_o[F_Z]);

    // R6
    logic_carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR)
        |=> (!flags_o[F_V] && $stable(flags_o[F_C]) && $stable(flags_o[F_H])));

    // R8
    incdec_carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_INC || op_i == OP_DEC)
        |=> ($stable(flags_o[F_C]) && $stable(flags_o[F_H])));

    // R11
    swap_flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SWAP) |=> $stable(flags_o));

    // R2
    idle_flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_NOP || op_i > OP_SWAP) |=> $stable(flags_o));
endmodule

bind alu8_flags alu8_flags_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .res_we_o (res_we_o),
    .flags_o  (flags_o)
);

// File: tb/alu8_flags_tb.sv
module alu8_flags_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op_i = 5'd0;
    logic [7:0] opd_a_i = 8'd0, opd_b_i = 8'd0;
    logic [7:0] res_o;
    logic       res_we_o;
    logic [5:0] flags_o;

    int checks = 0;
    int errors = 0;
    logic [5:0] fmodel = 6'd0;
    bit done = 0;

    alu8_flags u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .opd_a_i(opd_a_i),
        .opd_b_i(opd_b_i), .res_o(res_o), .res_we_o(res_we_o), .flags_o(flags_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int sx(input logic [7:0] v);
        return (v > 8'd127) ? int'(v) - 256 : int'(v);
    endfunction

    // Expected {we, result, flags} from the requirements (flags {H,S,V,N,Z,C}).
    function automatic logic [14:0] model(input logic [4:0] op, input logic [7:0] a,
                                          input logic [7:0] b, input logic [5:0] f);
        int r, sr, ci;
        logic [7:0] res = 8'd0;
        logic we = 1'b1;
        logic c = f[0], z = f[1], n = f[2], v = f[3], s = f[4], h = f[5];
        bit nv = 0;
        ci = int'(f[0]);
        case (op)
            1, 2: begin // R3
                if (op == 1) ci = 0;
                r = int'(a) + int'(b) + ci; res = r[7:0];
                c = r > 255; h = (int'(a % 16) + int'(b % 16) + ci) > 15;
                sr = sx(a) + sx(b) + ci; v = (sr > 127) || (sr < -128);
                z = res == 0; nv = 1;
            end
            3, 4, 5, 6: begin // R4 R5
                if (op == 3 || op == 5) ci = 0;
                r = int'(a) - int'(b) - ci; res = r[7:0];
                c = r < 0; h = (int'(a % 16) - int'(b % 16) - ci) < 0;
                sr = sx(a) - sx(b) - ci; v = (sr > 127) || (sr < -128);
                z = (op == 4 || op == 6) ? ((res == 0) && f[1]) : (res == 0);
                we = !(op == 5 || op == 6); nv = 1;
            end
            7, 8, 9: begin // R6
                res = (op == 7) ? (a & b) : (op == 8) ? (a | b) : (a ^ b);
                v = 0; z = res == 0; nv = 1;
            end
            10: begin res = 8'hFF - a; c = 1; v = 0; z = res == 0; nv = 1; end // R7
            11: begin // R7
                res = 8'(256 - int'(a)); c = a != 0; v = a == 8'h80;
                h = (a % 16) != 0; z = res == 0; nv = 1;
            end
            12, 13: begin // R8
                res = (op == 12) ? a + 8'd1 : a - 8'd1;
                v = (op == 12) ? (a == 8'h7F) : (a == 8'h80); z = res == 0; nv = 1;
            end
            14, 15, 16: begin // R9
                res = a / 2;
                if (op == 15) res = res + (f[0] ? 8'd128 : 8'd0);
                if (op == 16) res = res + (a & 8'h80);
                c = a[0]; n = res[7]; v = n ^ c; z = res == 0; nv = 1;
            end
            17, 18: begin // R10
                res = 8'(int'(a) * 2 + ((op == 18) ? ci : 0));
                c = a[7]; h = a[3]; n = res[7]; v = n ^ c; z = res == 0; nv = 1;
            end
            19: res = 8'((int'(a) % 16) * 16 + int'(a) / 16); // R11
            default: we = 0; // R2
        endcase
        if (nv) begin n = res[7]; s = n ^ v; end // R12
        return {we, res, h, s, v, n, z, c};
    endfunction

    function automatic string req_of(input logic [4:0] op);
        case (op)
            1, 2: return "R3";
            3, 5: return "R4";
            4, 6: return "R5";
            7, 8, 9: return "R6";
            10, 11: return "R7";
            12, 13: return "R8";
            14, 15, 16: return "R9";
            17, 18: return "R10";
            19: return "R11";
            default: return "R2";
        endcase
    endfunction

    // Present one operation at a falling edge; check result now, flags after the edge (R13).
    task automatic run(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b);
        logic [14:0] e;
        string tag;
        tag = req_of(op);
        op_i = op; opd_a_i = a; opd_b_i = b;
        #1;
        e = model(op, a, b, fmodel);
        checks++;
        if (res_we_o !== e[14] || (e[14] && res_o !== e[13:6])) begin
            errors++;
            $display("FAIL %s/R13 op=%0d a=%h b=%h we/res actual=%b/%h expected=%b/%h",
                     tag, op, a, b, res_we_o, res_o, e[14], e[13:6]);
        end
        @(negedge clk);
        checks++;
        if (flags_o !== e[5:0]) begin
            errors++;
            $display("FAIL %s/R12 op=%0d a=%h b=%h flags actual=%b expected=%b",
                     tag, op, a, b, flags_o, e[5:0]);
        end
        fmodel = e[5:0];
    endtask

    initial begin
        void'($urandom(32'd20240611));
        op_i = 5'd1; opd_a_i = 8'hFF; opd_b_i = 8'h01;
        repeat (3) @(negedge clk);
        checks++; // R1: reset clears flags even with an add presented
        if (flags_o !== 6'd0) begin
            errors++;
            $display("FAIL R1 reset flags actual=%b expected=%b", flags_o, 6'd0);
        end
        rst_n = 1'b1;

        // R3 corners: overflow, half carry, carry with zero, add-with-carry
        run(5'd1, 8'h7F, 8'h01);
        run(5'd1, 8'h0F, 8'h01);
        run(5'd1, 8'hFF, 8'h01);
        run(5'd2, 8'h10, 8'h20);
        // R4 borrow, then R5 chained compare: equal high byte keeps Z only if low was equal
        run(5'd3, 8'h00, 8'h01);
        run(5'd5, 8'h34, 8'h34);
        run(5'd6, 8'h12, 8'h12);
        run(5'd5, 8'h35, 8'h34);
        run(5'd6, 8'h12, 8'h12);
        run(5'd5, 8'h00, 8'h01);
        run(5'd4, 8'h13, 8'h12);
        // R6 after carry set, R7, R8 corners
        run(5'd1, 8'hFF, 8'h01);
        run(5'd7, 8'hF0, 8'h0F);
        run(5'd9, 8'h80, 8'h01);
        run(5'd10, 8'h55, 8'h00);
        run(5'd11, 8'h80, 8'h00);
        run(5'd11, 8'h00, 8'h00);
        run(5'd11, 8'h10, 8'h00);
        run(5'd12, 8'h7F, 8'h00);
        run(5'd13, 8'h80, 8'h00);
        run(5'd13, 8'h01, 8'h00);
        // R9, R10 with both carry values
        run(5'd16, 8'h81, 8'h00);
        run(5'd15, 8'h02, 8'h00);
        run(5'd14, 8'h01, 8'h00);
        run(5'd15, 8'h00, 8'h00);
        run(5'd18, 8'h88, 8'h00);
        run(5'd18, 8'h08, 8'h00);
        run(5'd17, 8'h40, 8'h00);
        // R11, R2
        run(5'd19, 8'hA5, 8'h00);
        run(5'd0, 8'hFF, 8'hFF);
        run(5'd25, 8'h00, 8'h00);

        // Random back-to-back operations, including unused codes
        for (int i = 0; i < N_RANDOM; i++) begin
            run(5'($urandom % 24), 8'($urandom), 8'($urandom));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule